// File: doc/BRIEF.md
# Processor Reset-State Sequencer

This block puts the control registers of a small processor core into their power-on values for as long as the external reset pin is held low. It holds the core idle for the whole of that time. Then it brings the core out of reset in a fixed order. The pin is active low. Assertion takes effect at once, without waiting for a clock. Release passes through a two-stage synchronizer, so the core always leaves reset on a clock edge.

On the first clock edge after the synchronized release, the sequencer samples the three mode pins. It copies them into the mode field of the operating-mode register. It also uses them to index an eight-entry boot-address table, which is a parameter, to produce the program-counter start value. From the same edge it raises the fetch enable. The decode enable follows one cycle later and the execute enable one cycle after that, because an instruction must be fetched and decoded before it can execute.

After startup the registers keep their values. Later changes on the mode pins have no effect until the next reset.

Top module: `proc_reset_seq`

## Requirements
- R1: While reset is active, every modifier register reads all ones (0xFFFF per register). After release each keeps that value.
- R2: While reset is active, the interrupt-priority register and the stack pointer read zero.
- R3: While reset is active, every 4-bit wait-state field of the bus-control register reads 15, so the whole register is 0xFFFF.
- R4: While reset is active, the status register reads 0x0300. Its fields are: loop flag at bit 15, double-precision multiply at bit 14, trace at bit 13, scaling at bits 11:10, condition codes at bits 7:0 (all cleared), and interrupt mask at bits 9:8 (set).
- R5: While reset is active, the operating-mode register reads 0x00. Its fields are: stop delay at bit 6, internal Y-memory disable at bit 5, data-ROM enable at bit 4, and operating mode at bits 2:0.
- R6: Fetch, decode and execute enables stay low for as long as the reset pin is low, however long that lasts.
- R7: When the pin is raised between two clock edges, fetch_en first reads high after the third following rising edge. At that same edge the mode pins are latched into operating-mode bits 2:0.
- R8: On that same edge pc_start takes the value of table entry m, where m is the mode value. Entry m occupies bits m*ADDR_W upward of BOOT_TABLE. While reset is active, pc_start reads zero.
- R9: decode_en rises one cycle after fetch_en and exec_en rises two cycles after fetch_en. All three then stay high.
- R10: Changes on the mode pins after release leave the operating-mode register and pc_start unchanged.
- R11: Lowering the reset pin while the core is running drops all enables and restores every reset value at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | External reset pin, active low |
| mode_pin | input | 3 | Mode-select pins, sampled at release |
| mod_regs | output | NUM_MOD*DATA_W | Modifier registers, concatenated |
| ipr | output | DATA_W | Interrupt-priority register |
| bcr | output | NUM_AREAS*WS_W | Bus-control register (wait-state fields) |
| sp | output | SP_W | Stack pointer |
| sr | output | 16 | Status register |
| omr | output | 8 | Operating-mode register |
| pc_start | output | ADDR_W | Program-counter start value |
| fetch_en | output | 1 | Instruction fetch enable |
| decode_en | output | 1 | Instruction decode enable |
| exec_en | output | 1 | Instruction execute enable |

## Verification
The bench sweeps all eight mode-pin values. It loads the boot table with distinct, arithmetically computed entries, so a wrong table index or a byte-swapped slice produces a visibly wrong start address. Each mode is held in reset for a different number of cycles. This separates an enable that leaks out of a long reset from one that is merely late. After each release the pins are inverted, which exposes any capture that is not limited to the release edge. Finally, reset is reasserted between clock edges to show that the return to the reset state does not wait for a clock.

// File: rtl/prs_pkg.sv
package prs_pkg;

   localparam int MODE_W   = 3;
   localparam int NUM_BOOT = 1 << MODE_W;
   localparam int SR_W     = 16;
   localparam int OMR_W    = 8;

   // Status register layout
   typedef struct packed {
      logic       loop_flag;   // 15
      logic       dp_mult;     // 14
      logic       trace;       // 13
      logic       rsvd;        // 12
      logic [1:0] scale;       // 11:10
      logic [1:0] imask;       // 9:8
      logic [7:0] ccr;         // 7:0
   } sr_t;

   // Operating-mode register layout
   typedef struct packed {
      logic              rsvd7;
      logic              stop_dly;   // 6
      logic              ymem_dis;   // 5
      logic              drom_en;    // 4
      logic              rsvd3;
      logic [MODE_W-1:0] mode;       // 2:0
   } omr_t;

   typedef enum logic [1:0] {
      ST_HOLD,
      ST_FETCH,
      ST_DECODE,
      ST_RUN
   } seq_state_t;

   function automatic sr_t sr_reset_value();
      sr_t v;
      v       = '0;
      v.imask = '1;
      return v;
   endfunction

   function automatic omr_t omr_reset_value();
      omr_t v;
      v = '0;
      return v;
   endfunction

endpackage

// File: rtl/prs_rst_sync.sv
module prs_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_pin_n,
   output logic rst_int
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("prs_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   // Asynchronous entry, release shifted through STAGES flops
   always_ff @(posedge clk or negedge rst_pin_n) begin
      if (!rst_pin_n) chain_q <= '0;
      else            chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_int = ~chain_q[STAGES-1];

   AST_RELEASE_NEEDS_PIN: assert property (@(posedge clk)
      $fell(rst_int) |-> $past(rst_pin_n)) else $error("release without pin"); // R7

endmodule

// File: rtl/prs_ctrl_regs.sv
module prs_ctrl_regs
   import prs_pkg::*;
#(
   parameter int NUM_MOD   = 4,
   parameter int DATA_W    = 16,
   parameter int NUM_AREAS = 4,
   parameter int WS_W      = 4,
   parameter int SP_W      = 6
) (
   input  logic                        clk,
   input  logic                        rst_int,
   input  logic                        mode_load,
   input  logic [MODE_W-1:0]           mode_val,
   output logic [NUM_MOD*DATA_W-1:0]   mod_regs,
   output logic [DATA_W-1:0]           ipr,
   output logic [NUM_AREAS*WS_W-1:0]   bcr,
   output logic [SP_W-1:0]             sp,
   output logic [SR_W-1:0]             sr,
   output logic [OMR_W-1:0]            omr
);

   localparam int MOD_TOTAL = NUM_MOD * DATA_W;
   localparam int BCR_TOTAL = NUM_AREAS * WS_W;

   generate
      if (NUM_MOD < 1 || DATA_W < 1) begin : g_bad_mod
         $error("prs_ctrl_regs: modifier bank must be non-empty");
      end
      if (NUM_AREAS < 1 || WS_W < 1) begin : g_bad_bcr
         $error("prs_ctrl_regs: bus-control fields must be non-empty");
      end
   endgenerate

   // Modifier bank: one register per address channel
   for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
      logic [DATA_W-1:0] m_q;
      always_ff @(posedge clk or posedge rst_int) begin
         if (rst_int) m_q <= '1;
      end
      assign mod_regs[i*DATA_W +: DATA_W] = m_q;
   end

   // Bus-control: one wait-state field per external area, max count at reset
   for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
      logic [WS_W-1:0] ws_q;
      always_ff @(posedge clk or posedge rst_int) begin
         if (rst_int) ws_q <= '1;
      end
      assign bcr[a*WS_W +: WS_W] = ws_q;
   end

   logic [DATA_W-1:0] ipr_q;
   logic [SP_W-1:0]   sp_q;
   sr_t               sr_q;
   omr_t              omr_q;

   always_ff @(posedge clk or posedge rst_int) begin
      if (rst_int) begin
         ipr_q <= '0;
         sp_q  <= '0;
         sr_q  <= sr_reset_value();
      end
   end

   // Mode field is written only on the release edge
   always_ff @(posedge clk or posedge rst_int) begin
      if (rst_int)        omr_q      <= omr_reset_value();
      else if (mode_load) omr_q.mode <= mode_val;
   end

   assign ipr = ipr_q;
   assign sp  = sp_q;
   assign sr  = sr_q;
   assign omr = omr_q;

   AST_MOD_HOLD: assert property (@(posedge clk) disable iff (rst_int)
      $stable(mod_regs) && $stable(bcr)) else $error("modifier or bus-control changed"); // R1

   AST_MODE_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (rst_int)
      !$past(mode_load) |-> $stable(omr)) else $error("mode changed outside release"); // R10

endmodule

// File: rtl/prs_startup.sv
module prs_startup
   import prs_pkg::*;
#(
   parameter int                         ADDR_W     = 16,
   parameter logic [NUM_BOOT*ADDR_W-1:0] BOOT_TABLE = '0
) (
   input  logic              clk,
   input  logic              rst_int,
   input  logic [MODE_W-1:0] mode_pin,
   output logic              mode_load,
   output logic [ADDR_W-1:0] pc_start,
   output logic              fetch_en,
   output logic              decode_en,
   output logic              exec_en
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("prs_startup: ADDR_W must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0] boot_addr [NUM_BOOT];

   for (genvar e = 0; e < NUM_BOOT; e++) begin : g_boot
      assign boot_addr[e] = BOOT_TABLE[e*ADDR_W +: ADDR_W];
   end

   seq_state_t st_q, st_d;

   always_comb begin
      case (st_q)
         ST_HOLD:   st_d = ST_FETCH;
         ST_FETCH:  st_d = ST_DECODE;
         ST_DECODE: st_d = ST_RUN;
         default:   st_d = ST_RUN;
      endcase
   end

   // In ST_HOLD with reset released: this edge is the release edge
   assign mode_load = (st_q == ST_HOLD);

   always_ff @(posedge clk or posedge rst_int) begin
      if (rst_int) begin
         st_q     <= ST_HOLD;
         pc_start <= '0;
      end else begin
         st_q <= st_d;
         if (mode_load) pc_start <= boot_addr[mode_pin];
      end
   end

   assign fetch_en  = (st_q != ST_HOLD);
   assign decode_en = (st_q == ST_DECODE) || (st_q == ST_RUN);
   assign exec_en   = (st_q == ST_RUN);

   AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst_int)
      $rose(decode_en) |-> $past(fetch_en)) else $error("decode before fetch"); // R9

   AST_EXEC_AFTER_DECODE: assert property (@(posedge clk) disable iff (rst_int)
      $rose(exec_en) |-> $past(decode_en) && $past(fetch_en, 2)) else $error("execute too early"); // R9

   AST_BOOT_STABLE: assert property (@(posedge clk) disable iff (rst_int)
      fetch_en && $past(fetch_en) |-> $stable(pc_start)) else $error("start address moved"); // R10

endmodule

// File: rtl/proc_reset_seq.sv
module proc_reset_seq
   import prs_pkg::*;
#(
   parameter int                         NUM_MOD     = 4,
   parameter int                         DATA_W      = 16,
   parameter int                         NUM_AREAS   = 4,
   parameter int                         WS_W        = 4,
   parameter int                         SP_W        = 6,
   parameter int                         ADDR_W      = 16,
   parameter int                         SYNC_STAGES = 2,
   parameter logic [NUM_BOOT*ADDR_W-1:0] BOOT_TABLE  = '0
) (
   input  logic                        clk,
   input  logic                        rst_pin_n,
   input  logic [MODE_W-1:0]           mode_pin,
   output logic [NUM_MOD*DATA_W-1:0]   mod_regs,
   output logic [DATA_W-1:0]           ipr,
   output logic [NUM_AREAS*WS_W-1:0]   bcr,
   output logic [SP_W-1:0]             sp,
   output logic [SR_W-1:0]             sr,
   output logic [OMR_W-1:0]            omr,
   output logic [ADDR_W-1:0]           pc_start,
   output logic                        fetch_en,
   output logic                        decode_en,
   output logic                        exec_en
);

   logic rst_int;
   logic mode_load;

   prs_rst_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_pin_n (rst_pin_n),
      .rst_int   (rst_int)
   );

   prs_ctrl_regs #(
      .NUM_MOD   (NUM_MOD),
      .DATA_W    (DATA_W),
      .NUM_AREAS (NUM_AREAS),
      .WS_W      (WS_W),
      .SP_W      (SP_W)
   ) u_regs (
      .clk       (clk),
      .rst_int   (rst_int),
      .mode_load (mode_load),
      .mode_val  (mode_pin),
      .mod_regs  (mod_regs),
      .ipr       (ipr),
      .bcr       (bcr),
      .sp        (sp),
      .sr        (sr),
      .omr       (omr)
   );

   prs_startup #(
      .ADDR_W     (ADDR_W),
      .BOOT_TABLE (BOOT_TABLE)
   ) u_start (
      .clk       (clk),
      .rst_int   (rst_int),
      .mode_pin  (mode_pin),
      .mode_load (mode_load),
      .pc_start  (pc_start),
      .fetch_en  (fetch_en),
      .decode_en (decode_en),
      .exec_en   (exec_en)
   );

   AST_NO_RUN_IN_RESET: assert property (@(posedge clk)
      rst_int |-> !fetch_en && !decode_en && !exec_en) else $error("enable during reset"); // R6

   AST_MODE_MATCHES_LOAD: assert property (@(posedge clk) disable iff (rst_int)
      $rose(fetch_en) |-> omr[MODE_W-1:0] == $past(mode_pin)) else $error("mode not latched"); // R7

endmodule

// File: tb/tb_proc_reset_seq.sv
`timescale 1ns/100ps
module tb_proc_reset_seq;

   localparam int ADDR_W = 16;
   localparam int NB     = 8;

   function automatic logic [ADDR_W-1:0] entry_of(int m);
      return ADDR_W'(m * 16'h0A00 + 16'h0040);
   endfunction

   function automatic logic [NB*ADDR_W-1:0] make_table();
      logic [NB*ADDR_W-1:0] t;
      for (int m = 0; m < NB; m++) t[m*ADDR_W +: ADDR_W] = entry_of(m);
      return t;
   endfunction

   localparam logic [NB*ADDR_W-1:0] TBL = make_table();

   logic        clk = 1'b0;
   logic        rst_pin_n = 1'b0;
   logic [2:0]  mode_pin = 3'd0;
   logic [63:0] mod_regs;
   logic [15:0] ipr, bcr, sr, pc_start;
   logic [5:0]  sp;
   logic [7:0]  omr;
   logic        fetch_en, decode_en, exec_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   proc_reset_seq #(.ADDR_W(ADDR_W), .BOOT_TABLE(TBL)) dut (
      .clk(clk), .rst_pin_n(rst_pin_n), .mode_pin(mode_pin),
      .mod_regs(mod_regs), .ipr(ipr), .bcr(bcr), .sp(sp), .sr(sr), .omr(omr),
      .pc_start(pc_start), .fetch_en(fetch_en), .decode_en(decode_en), .exec_en(exec_en)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_reset_vals(string tag);
      chk({tag, " R1 modifiers"}, mod_regs, 64'hFFFF_FFFF_FFFF_FFFF);
      chk({tag, " R2 ipr"}, 64'(ipr), 64'h0);
      chk({tag, " R2 sp"}, 64'(sp), 64'h0);
      chk({tag, " R3 bcr"}, 64'(bcr), 64'hFFFF);
      chk({tag, " R4 sr"}, 64'(sr), 64'h0300);
      chk({tag, " R5 omr"}, 64'(omr), 64'h00);
      chk({tag, " R8 pc in reset"}, 64'(pc_start), 64'h0);
   endtask

   task automatic chk_en(string req, logic f, logic d, logic e);
      chk(req, {61'd0, fetch_en, decode_en, exec_en}, {61'd0, f, d, e});
   endtask

   initial begin
      for (int m = 0; m < NB; m++) begin
         mode_pin = 3'(m);
         // hold reset for a mode-dependent length
         for (int c = 0; c < 3 + 2 * m; c++) begin
            @(negedge clk);
            chk_en("R6 idle while pin low", 1'b0, 1'b0, 1'b0);
         end
         chk_reset_vals("hold");
         rst_pin_n = 1'b1;
         @(negedge clk); chk_en("R7 edge1", 1'b0, 1'b0, 1'b0);
         @(negedge clk); chk_en("R7 edge2", 1'b0, 1'b0, 1'b0);
         @(negedge clk); chk_en("R7 edge3 fetch", 1'b1, 1'b0, 1'b0);
         chk("R7 mode latched", 64'(omr), 64'(m));
         chk("R8 boot address", 64'(pc_start), 64'(entry_of(m)));
         @(negedge clk); chk_en("R9 decode", 1'b1, 1'b1, 1'b0);
         @(negedge clk); chk_en("R9 execute", 1'b1, 1'b1, 1'b1);
         mode_pin = ~3'(m);
         for (int c = 0; c < 3; c++) @(negedge clk);
         chk_en("R9 stays running", 1'b1, 1'b1, 1'b1);
         chk("R10 mode unchanged", 64'(omr), 64'(m));
         chk("R10 pc unchanged", 64'(pc_start), 64'(entry_of(m)));
         chk("R1 modifiers held", mod_regs, 64'hFFFF_FFFF_FFFF_FFFF);
         chk("R4 sr held", 64'(sr), 64'h0300);
         // asynchronous reassertion between edges
         #0.5 rst_pin_n = 1'b0;
         #0.5;
         chk_en("R11 enables dropped", 1'b0, 1'b0, 1'b0);
         chk_reset_vals("R11 async");
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule